// File: doc/BRIEF.md
# Packed Two-Entry Colour Lookup Table

This block holds the colour lookup table of a display pipeline. Software programs it over a simple register bus as 128 words of 32 bits, and each word carries two table entries of 16 bits. The pixel path sends an 8-bit index on a separate port. One clock later the block returns a 24-bit red/green/blue colour with 8 bits per channel.

Each entry packs three 5-bit channel fields and one intensity bit, which the block ignores. A channel is widened to 8 bits by placing its 5 bits at the top and filling the low three bits with zero. A bus read returns the stored 32-bit word unchanged, not the widened colour. A swap control exchanges the red and blue channels on the lookup output, for panels that wire their channels in the opposite order.

Top module: `clut_pair_ram`

## Requirements
- R1: The table window spans byte addresses 0x200 through 0x3FF. Word n (0..127) is selected by address bits [8:2] at address 0x200 + 4n, and address bits [1:0] have no effect. A write whose address falls outside the window changes no stored word.
- R2: A bus read inside the window puts the stored 32-bit word, exactly as written, on `bus_rdata` after the next rising edge. `bus_rdata` keeps its value in every cycle without a read.
- R3: A bus read outside the window returns zero on `bus_rdata` after the next rising edge.
- R4: Lookup index 2n uses bits [15:0] of word n, and index 2n+1 uses bits [31:16] of word n.
- R5: Within an entry, bits [4:0] are red, bits [9:5] are green and bits [14:10] are blue. Bit 15 (intensity) has no effect on the output colour.
- R6: Each 5-bit channel appears on its 8-bit output as the field shifted left by three, so output bits [2:0] are always zero.
- R7: When `pix_en` is high at a rising edge, the colour for `pix_idx` appears on the outputs after that edge. While `pix_en` is low, the outputs hold their value.
- R8: When `bgr_swap` is high at the lookup edge, `col_r` carries the blue field and `col_b` carries the red field. Green is unchanged.
- R9: After reset, `col_r`, `col_g`, `col_b` and `bus_rdata` are zero.
- R10: A lookup or a bus read in the same cycle as a write to the same word returns the contents from before that write. The new contents are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |
| pix_en | input | 1 | Lookup clock enable |
| pix_idx | input | 8 | Pixel index |
| bgr_swap | input | 1 | Exchange red and blue on output |
| col_r | output | 8 | Red channel |
| col_g | output | 8 | Green channel |
| col_b | output | 8 | Blue channel |

## Verification
Some rules are checked by assertions in every cycle:
- the output colours hold while the lookup enable is low;
- the read data holds when no read is issued;
- reads outside the window return zero;
- the three low bits of every channel stay zero.

The bench scenarios cover the rules that depend on data. These are the half-word selection by index parity, the channel field positions, the ignored intensity bit and the red/blue exchange. They also include writes outside the window that must not alias into the table, and the old-data result when a write and a lookup hit the same word in the same cycle.

// File: rtl/clut_pair_pkg.sv
`timescale 1ns/1ps
package clut_pair_pkg;
  localparam int ADDR_W   = 12;
  localparam int WORD_W   = 32;
  localparam int CH_IN_W  = 5;
  localparam int CH_OUT_W = 8;
  localparam int ENT_W    = WORD_W / 2;
  localparam int PAD_W    = CH_OUT_W - CH_IN_W;

  typedef struct packed {
    logic [CH_OUT_W-1:0] r;
    logic [CH_OUT_W-1:0] g;
    logic [CH_OUT_W-1:0] b;
  } rgb_t;

  function automatic logic [CH_OUT_W-1:0] widen(input logic [CH_IN_W-1:0] f);
    return {f, {PAD_W{1'b0}}};
  endfunction
endpackage

// File: rtl/clut_pair_decode.sv
`timescale 1ns/1ps
module clut_pair_decode #(
  parameter int ADDR_W   = 12,
  parameter int WORDS    = 128,
  parameter int WIN_BASE = 'h200
) (
  input  logic [ADDR_W-1:0]          addr,
  output logic                       hit,
  output logic [$clog2(WORDS)-1:0]   word_idx
);
  localparam int IDX_W     = $clog2(WORDS);
  localparam int WIN_SHIFT = IDX_W + 2;
  localparam logic [ADDR_W-WIN_SHIFT-1:0] WIN_TAG = (ADDR_W-WIN_SHIFT)'(WIN_BASE >> WIN_SHIFT);

  logic [1:0] byte_lane_unused;

  always_comb begin
    hit              = (addr[ADDR_W-1:WIN_SHIFT] == WIN_TAG);
    word_idx         = addr[WIN_SHIFT-1:2];
    byte_lane_unused = addr[1:0];
  end
endmodule

// File: rtl/clut_pair_store.sv
`timescale 1ns/1ps
module clut_pair_store #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [$clog2(WORDS)-1:0]  wr_idx,
  input  logic [WORD_W-1:0]         wr_data,
  input  logic [$clog2(WORDS)-1:0]  bus_idx,
  output logic [WORD_W-1:0]         bus_word,
  input  logic [$clog2(WORDS)-1:0]  pix_word_idx,
  output logic [WORD_W-1:0]         pix_word
);
  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    bus_word = mem[bus_idx];
    pix_word = mem[pix_word_idx];
  end
endmodule

// File: rtl/clut_pair_expand.sv
`timescale 1ns/1ps
module clut_pair_expand
  import clut_pair_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic              sel_hi,
  input  logic              swap,
  output rgb_t              rgb
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0]  entry;
  logic [CH_IN_W-1:0] f_r, f_g, f_b;
  logic               intensity_unused;

  always_comb begin
    entry            = sel_hi ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
    f_r              = entry[CH_IN_W-1:0];
    f_g              = entry[2*CH_IN_W-1:CH_IN_W];
    f_b              = entry[3*CH_IN_W-1:2*CH_IN_W];
    intensity_unused = entry[HALF_W-1];
    rgb.g            = widen(f_g);
    if (swap) begin
      rgb.r = widen(f_b);
      rgb.b = widen(f_r);
    end else begin
      rgb.r = widen(f_r);
      rgb.b = widen(f_b);
    end
  end
endmodule

// File: rtl/clut_pair_ram.sv
`timescale 1ns/1ps
module clut_pair_ram
  import clut_pair_pkg::*;
#(
  parameter int A_W      = 12,
  parameter int WORDS    = 128,
  parameter int WIN_BASE = 'h200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [A_W-1:0]       bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic                 pix_en,
  input  logic [7:0]           pix_idx,
  input  logic                 bgr_swap,
  output logic [7:0]           col_r,
  output logic [7:0]           col_g,
  output logic [7:0]           col_b
);
  localparam int IDX_W = $clog2(WORDS);

  logic              hit;
  logic [IDX_W-1:0]  bus_idx;
  logic [WORD_W-1:0] bus_word, pix_word;
  rgb_t              rgb_next, rgb_q;
  logic [WORD_W-1:0] rdata_next, rdata_q;

  clut_pair_decode #(.ADDR_W(A_W), .WORDS(WORDS), .WIN_BASE(WIN_BASE)) u_dec (
    .addr(bus_addr), .hit(hit), .word_idx(bus_idx)
  );

  clut_pair_store #(.WORDS(WORDS), .WORD_W(WORD_W)) u_store (
    .clk(clk),
    .wr_en(bus_wr_en && hit),
    .wr_idx(bus_idx),
    .wr_data(bus_wdata),
    .bus_idx(bus_idx),
    .bus_word(bus_word),
    .pix_word_idx(pix_idx[IDX_W:1]),
    .pix_word(pix_word)
  );

  rgb_t rgb_lut;
  clut_pair_expand #(.WORD_W(WORD_W)) u_exp (
    .word(pix_word), .sel_hi(pix_idx[0]), .swap(bgr_swap), .rgb(rgb_lut)
  );

  always_comb begin
    rgb_next   = pix_en ? rgb_lut : rgb_q;
    rdata_next = rdata_q;
    if (bus_rd_en) begin
      rdata_next = hit ? bus_word : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgb_q   <= '0;
      rdata_q <= '0;
    end else begin
      rgb_q   <= rgb_next;
      rdata_q <= rdata_next;
    end
  end

  always_comb begin
    col_r     = rgb_q.r;
    col_g     = rgb_q.g;
    col_b     = rgb_q.b;
    bus_rdata = rdata_q;
  end
endmodule

module clut_pair_ram_chk #(
  parameter int A_W      = 12,
  parameter int WORDS    = 128,
  parameter int WIN_BASE = 'h200
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_rd_en,
  input logic [A_W-1:0] bus_addr,
  input logic [31:0]    bus_rdata,
  input logic           pix_en,
  input logic [7:0]     col_r,
  input logic [7:0]     col_g,
  input logic [7:0]     col_b
);
  localparam int SPAN = WORDS * 4;
  logic in_win;
  assign in_win = (int'(bus_addr) >= WIN_BASE) && (int'(bus_addr) < WIN_BASE + SPAN);

  a_r3_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && !in_win) |=> (bus_rdata == 32'h0));

  a_r2_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_en |=> $stable(bus_rdata));

  a_r7_colour_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(col_r) && $stable(col_g) && $stable(col_b)));

  a_r6_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pix_en |=> (col_r[2:0] == 3'b0 && col_g[2:0] == 3'b0 && col_b[2:0] == 3'b0));
endmodule

bind clut_pair_ram clut_pair_ram_chk #(.A_W(A_W), .WORDS(WORDS), .WIN_BASE(WIN_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd_en(bus_rd_en), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pix_en(pix_en), .col_r(col_r), .col_g(col_g), .col_b(col_b)
);

// File: tb/clut_pair_ram_bench.sv
`timescale 1ns/1ps
module clut_pair_ram_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr_en, bus_rd_en, pix_en, bgr_swap, hold_chk;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  pix_idx, col_r, col_g, col_b;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] model [128];
  string       pix_tag_q[$];
  logic [23:0] pix_exp_q[$];
  string       rd_tag_q[$];
  logic [31:0] rd_exp_q[$];
  logic [23:0] hold_ref = '0;

  always #2 clk = ~clk;

  clut_pair_ram u_clut_pair_ram (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_en(pix_en), .pix_idx(pix_idx), .bgr_swap(bgr_swap),
    .col_r(col_r), .col_g(col_g), .col_b(col_b)
  );

  function automatic logic [23:0] exp_col(input logic [7:0] idx, input logic bg);
    logic [31:0] w;
    logic [15:0] e;
    logic [7:0]  r, g, b;
    w = model[idx[7:1]];
    e = idx[0] ? w[31:16] : w[15:0];
    r = {e[4:0], 3'b000};
    g = {e[9:5], 3'b000};
    b = {e[14:10], 3'b000};
    return bg ? {b, g, r} : {r, g, b};
  endfunction

  function automatic bit in_win(input logic [11:0] a);
    return a >= 12'h200 && a < 12'h400;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic we, input logic re, input logic [11:0] a, input logic [31:0] d,
                     input logic pe, input logic [7:0] pi, input logic bg, input string tag);
    @(negedge clk);
    bus_wr_en = we; bus_rd_en = re; bus_addr = a; bus_wdata = d;
    pix_en = pe; pix_idx = pi; bgr_swap = bg; hold_chk = 1'b0;
    if (re) begin
      rd_tag_q.push_back(in_win(a) ? tag : "R3");
      rd_exp_q.push_back(in_win(a) ? model[a[8:2]] : 32'h0);
    end
    if (pe) begin
      pix_tag_q.push_back(tag);
      pix_exp_q.push_back(exp_col(pi, bg));
    end
    if (we && in_win(a)) model[a[8:2]] = d;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b0, a, d, 1'b0, 8'h0, 1'b0, tag);
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 32'h0, 1'b0, 8'h0, 1'b0, tag);
  endtask
  task automatic lk(input logic [7:0] i, input logic bg, input string tag);
    cyc(1'b0, 1'b0, 12'h0, 32'h0, 1'b1, i, bg, tag);
  endtask
  task automatic idle_hold(input logic [7:0] i);
    @(negedge clk);
    bus_wr_en = 0; bus_rd_en = 0; pix_en = 0; pix_idx = i; bgr_swap = ~bgr_swap; hold_chk = 1'b1;
  endtask

  // Monitor: captures strobes at the edge, compares 1 ns later.
  always @(posedge clk) begin
    logic tp, tr, th;
    tp = pix_en && rst_n;
    tr = bus_rd_en && rst_n;
    th = hold_chk && rst_n;
    #1;
    if (tp) begin
      if (pix_exp_q.size() == 0) check("R7 extra", 32'h1, 32'h0);
      else begin
        hold_ref = pix_exp_q.pop_front();
        check(pix_tag_q.pop_front(), {8'h0, col_r, col_g, col_b}, {8'h0, hold_ref});
      end
    end else if (th) begin
      check("R7 hold", {8'h0, col_r, col_g, col_b}, {8'h0, hold_ref});
    end
    if (tr) begin
      if (rd_exp_q.size() == 0) check("R2 extra", 32'h1, 32'h0);
      else check(rd_tag_q.pop_front(), bus_rdata, rd_exp_q.pop_front());
    end
  end

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 0; bus_wr_en = 0; bus_rd_en = 0; bus_addr = '0; bus_wdata = '0;
    pix_en = 0; pix_idx = '0; bgr_swap = 0; hold_chk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 colour", {8'h0, col_r, col_g, col_b}, 32'h0);
    check("R9 rdata", bus_rdata, 32'h0);

    // R1: fill every word
    for (int n = 0; n < 128; n++)
      wr(12'h200 + 12'(4 * n), {8'(n * 3 + 1), 8'(~n), 8'(n * 11), 8'(n ^ 8'hA5)}, "R1");
    rd(12'h200, "R2");
    rd(12'h207, "R1");
    rd(12'h2FD, "R1");
    rd(12'h3FE, "R2");

    // R1/R3: outside writes do not alias, outside reads return zero
    wr(12'h1FC, 32'hDEAD_BEEF, "R1");
    wr(12'h400, 32'hCAFE_F00D, "R1");
    rd(12'h1FC, "R3");
    rd(12'h400, "R3");
    rd(12'h3FC, "R1");
    rd(12'h200, "R1");

    // R4: every index, no swap; R8: sampled indices with swap
    for (int i = 0; i < 256; i++) lk(8'(i), 1'b0, "R4");
    for (int i = 0; i < 256; i += 17) lk(8'(i), 1'b1, "R8");

    // R5/R6: field positions, intensity ignored, widening
    wr(12'h214, 32'hFFFF_8000, "R5");
    wr(12'h218, 32'h03E0_001F, "R5");
    wr(12'h21C, 32'h0421_7C00, "R6");
    lk(8'd10, 1'b0, "R5");
    lk(8'd11, 1'b0, "R5");
    lk(8'd12, 1'b0, "R5");
    lk(8'd13, 1'b0, "R5");
    lk(8'd14, 1'b0, "R5");
    lk(8'd15, 1'b0, "R6");
    lk(8'd15, 1'b1, "R8");

    // R7: hold while the enable is low
    lk(8'd12, 1'b0, "R7");
    idle_hold(8'd13);
    idle_hold(8'd200);
    idle_hold(8'd15);

    // R10: same-cycle write and lookup/read see old contents
    cyc(1'b1, 1'b0, 12'h21C, 32'h1234_5678, 1'b1, 8'd14, 1'b0, "R10");
    lk(8'd14, 1'b0, "R10");
    cyc(1'b1, 1'b1, 12'h21C, 32'h0BAD_CAFE, 1'b0, 8'd0, 1'b0, "R10");
    rd(12'h21C, "R10");

    @(negedge clk);
    bus_wr_en = 0; bus_rd_en = 0; pix_en = 0; hold_chk = 0;
    repeat (3) @(negedge clk);
    check("R7 drained", 32'(pix_exp_q.size() + rd_exp_q.size()), 32'h0);
    finish_up();
  end
endmodule